// File: doc/BRIEF.md
# Framed SPI Transaction Master

This block is a serial master that runs complete register transactions against a peripheral that has a four-wire serial interface. One chip-select window carries a register address byte, then a control byte, then between one and fifteen data bytes. The control byte tells the peripheral the direction of the transfer and how many data bytes follow. The block also drives an active-low reset line to the peripheral and contains its own serial clock divider.

The user side starts a transaction with a one-cycle start strobe. It presents the address, a direction flag and a 4-bit byte count with that strobe. On a write, the data bytes are pulled in one at a time through a ready/valid handshake. On a read, each received byte appears on a data output with a one-cycle valid strobe. A one-cycle done pulse closes every accepted transaction. A count of zero is refused at once with an error pulse.

A separate reset request pulls the peripheral reset low for a fixed number of system clocks. No transaction can be accepted during that time.

Top module: `spi_frame_master`

## Requirements
- R1: `cs_n` is 1 while the block is idle and 0 for the whole transaction. `sclk` is never 1 while `cs_n` is 1. The first byte shifted out in a window is `addr` and the second is the control byte.
- R2: The control byte has `wr_dir` in bit 7 and `len` in bits 3..0, and bits 6..4 are 0. `wr_dir`=1 means write and 0 means read.
- R3: `sclk` idles at 0. `mosi` changes only while `sclk` is 0, so `mosi` has the same value in the cycle `sclk` rises and throughout the high phase.
- R4: An accepted transaction makes exactly 8*(`len`+2) rising edges of `sclk`. Every byte is sent most-significant bit first.
- R5: On a write, the data bytes are taken through `wvalid`/`wready` in order. While the next byte is awaited, `wready` is 1, `sclk` stays at 0 and no further edges occur.
- R6: On a read, one `miso` bit is sampled at each rising edge of `sclk`, most-significant first. Each completed byte is presented on `rdata` with a one-cycle `rvalid`. `mosi` is 0 during read data bytes.
- R7: A start with `len`=0 while idle gives a one-cycle `err` in the next cycle. `cs_n` does not fall and `busy` stays 0.
- R8: `busy` is 1 from the cycle after an accepted start until the transaction ends. `done` is then 1 for one cycle, and in that same cycle `cs_n` is 1 and `busy` is 0.
- R9: A start that arrives while `busy` is 1 is ignored. It gives no `err` and no new chip-select window, and the running transaction continues unchanged.
- R10: A cycle with `rst_req`=1 holds `per_rst_n` at 0 for exactly RST_CYCLES cycles. A start during that time gives no transaction and no `err`.
- R11: Each high phase of `sclk` lasts exactly HALF_DIV system clocks, and each low phase inside a byte lasts HALF_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transaction |
| addr | input | 8 | Register address sent first |
| wr_dir | input | 1 | 1 = write, 0 = read |
| len | input | 4 | Number of data bytes, 1 to 15 |
| wdata | input | 8 | Write data byte |
| wvalid | input | 1 | Write data byte available |
| wready | output | 1 | Block takes `wdata` this cycle if `wvalid` |
| rdata | output | 8 | Received read byte |
| rvalid | output | 1 | `rdata` holds a new byte this cycle |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | One-cycle refusal of a zero-length request |
| busy | output | 1 | Transaction in progress |
| rst_req | input | 1 | Request a peripheral reset pulse |
| per_rst_n | output | 1 | Active-low peripheral reset |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to peripheral |
| miso | input | 1 | Serial data from peripheral |
| cs_n | output | 1 | Active-low chip select |

## Verification
Results arrive at fixed delays after the clock edge that samples a request. `err` and the rise of `busy` come one cycle after the start edge. `per_rst_n` falls one cycle after the `rst_req` edge. `done` comes in the same cycle as the return of `cs_n`, and each `rvalid` comes in the cycle `sclk` falls after the eighth bit of a read byte. Inputs change on falling clock edges and outputs are read on falling edges, so each check reads a value that has been stable for half a clock. The serial side is checked by a peripheral model in the bench that samples `mosi` and counts rising edges of `sclk`, so framing and edge counts are checked without reference to internal timing.

// File: rtl/spi_frame_pkg.sv
// Package: shared types and helpers for the framed serial master.
// Assumes byte-wide addresses and data and a 4-bit length code.
package spi_frame_pkg;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = 4;
    localparam int IDX_W  = LEN_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_WAIT,
        ST_TRAIL
    } sfm_state_t;

    // Build the control byte: direction on top, reserved zeros, length below.
    function automatic logic [BYTE_W-1:0] make_ctrl(input logic wr, input logic [LEN_W-1:0] n);
        return {wr, {(BYTE_W-LEN_W-1){1'b0}}, n};
    endfunction
endpackage

// File: rtl/sfm_clkdiv.sv
// Half-period tick generator. While run is high it pulses tick once every
// HALF_DIV cycles. The count restarts from zero whenever run is low.
// Assumes HALF_DIV >= 1.
module sfm_clkdiv #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    // Count system clocks within a half period, clearing when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sfm_rstctl.sv
// Peripheral reset pulse generator. A request loads a down-counter. The
// active-low reset output is low while the counter is nonzero, and hold
// blocks new transactions for that time. A new request restarts the count.
module sfm_rstctl #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req,
    output logic per_rst_n,
    output logic hold
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    logic [RW-1:0] cnt;

    assign hold      = (cnt != '0);
    assign per_rst_n = !hold;

    // Load on request, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (rst_req)  cnt <= RW'(RST_CYCLES);
        else if (hold)     cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/sfm_engine.sv
// Transaction sequencer and shifter. Frames address, control byte and data
// bytes under one chip-select window. The clock idles low, data is shifted
// out MSB first and changes on falling edges, and input is sampled on rising
// edges. Assumes tick comes from a divider that runs while run is high.
module sfm_engine
    import spi_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold,
    input  logic              start,
    input  logic [BYTE_W-1:0] addr,
    input  logic              wr_dir,
    input  logic [LEN_W-1:0]  len,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wvalid,
    input  logic              miso,
    output logic              run,
    output logic              wready,
    output logic [BYTE_W-1:0] rdata,
    output logic              rvalid,
    output logic              done,
    output logic              err,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);
    localparam int BC_W = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] BIT_LAST = BC_W'(BYTE_W - 1);

    sfm_state_t        state;
    logic [BYTE_W-1:0] sr, rx, ctrl_q;
    logic [BC_W-1:0]   bit_cnt;
    logic [IDX_W-1:0]  byte_idx;
    logic [LEN_W-1:0]  len_q;
    logic              dir_q, sclk_q;
    logic              last_byte;

    assign last_byte = (byte_idx == ({1'b0, len_q} + 1'b1));
    assign run       = (state == ST_SHIFT) || (state == ST_TRAIL);
    assign wready    = (state == ST_WAIT);
    assign busy      = (state != ST_IDLE);
    assign cs_n      = (state == ST_IDLE);
    assign sclk      = sclk_q;
    assign mosi      = busy && sr[BYTE_W-1];

    // Sequence the frame: accept, shift bytes, fetch write data, close window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sr       <= '0;
            rx       <= '0;
            ctrl_q   <= '0;
            bit_cnt  <= '0;
            byte_idx <= '0;
            len_q    <= '0;
            dir_q    <= 1'b0;
            sclk_q   <= 1'b0;
            rdata    <= '0;
            rvalid   <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            rvalid <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start && !hold) begin
                        if (len == '0) begin
                            err <= 1'b1;
                        end else begin
                            len_q    <= len;
                            dir_q    <= wr_dir;
                            ctrl_q   <= make_ctrl(wr_dir, len);
                            sr       <= addr;
                            bit_cnt  <= '0;
                            byte_idx <= '0;
                            sclk_q   <= 1'b0;
                            state    <= ST_SHIFT;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (tick && !sclk_q) begin
                        sclk_q <= 1'b1;
                        rx     <= {rx[BYTE_W-2:0], miso};
                    end else if (tick) begin
                        sclk_q <= 1'b0;
                        if (bit_cnt != BIT_LAST) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            sr      <= {sr[BYTE_W-2:0], 1'b0};
                        end else begin
                            bit_cnt <= '0;
                            if (byte_idx >= IDX_W'(2) && !dir_q) begin
                                rdata  <= rx;
                                rvalid <= 1'b1;
                            end
                            if (last_byte) begin
                                state <= ST_TRAIL;
                            end else begin
                                byte_idx <= byte_idx + 1'b1;
                                if (byte_idx == '0) sr <= ctrl_q;
                                else if (dir_q)     state <= ST_WAIT;
                                else                sr <= '0;
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (wvalid) begin
                        sr    <= wdata;
                        state <= ST_SHIFT;
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_frame_master.sv
// Top level of the framed serial master. Ties together the half-period
// divider, the peripheral reset pulse generator and the transaction engine.
// Assumes HALF_DIV >= 1 and RST_CYCLES >= 1.
module spi_frame_master #(
    parameter int HALF_DIV   = 4,
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] addr,
    input  logic       wr_dir,
    input  logic [3:0] len,
    input  logic [7:0] wdata,
    input  logic       wvalid,
    output logic       wready,
    output logic [7:0] rdata,
    output logic       rvalid,
    output logic       done,
    output logic       err,
    output logic       busy,
    input  logic       rst_req,
    output logic       per_rst_n,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso,
    output logic       cs_n
);
    logic tick, run, hold;

    sfm_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
    );

    sfm_rstctl #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req),
        .per_rst_n(per_rst_n), .hold(hold)
    );

    sfm_engine u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold(hold),
        .start(start), .addr(addr), .wr_dir(wr_dir), .len(len),
        .wdata(wdata), .wvalid(wvalid), .miso(miso),
        .run(run), .wready(wready), .rdata(rdata), .rvalid(rvalid),
        .done(done), .err(err), .busy(busy),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );
endmodule

// File: rtl/sfm_checker.sv
// Protocol checker for the framed serial master, attached with bind.
// It watches only the top-level ports and keeps its own phase counters.
module sfm_checker #(
    parameter int HALF_DIV   = 4,
    parameter int RST_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic wready,
    input logic per_rst_n
);
    logic [31:0] hi_len, lo_len;

    // Measure the current high phase of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !sclk) hi_len <= '0;
        else                 hi_len <= hi_len + 1;
    end

    // Measure the current low phase of the peripheral reset.
    always_ff @(posedge clk) begin
        if (!rst_n || per_rst_n) lo_len <= '0;
        else                     lo_len <= lo_len + 1;
    end

    // R3
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    // R1
    sclk_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R11
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_len == 32'(HALF_DIV)));

    // R10
    rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(per_rst_n) |-> (lo_len == 32'(RST_CYCLES)));

    // R10
    no_start_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(per_rst_n));

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && !busy));

    // R8
    done_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy && $past(busy)));

    // R5
    stall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wready |-> !sclk);
endmodule

bind spi_frame_master sfm_checker #(.HALF_DIV(HALF_DIV), .RST_CYCLES(RST_CYCLES)) u_chk (.*);

// File: tb/tb_spi_frame_master.sv
module tb_spi_frame_master;
    localparam int CLK_PERIOD = 10;
    localparam int HD = 2;
    localparam int RC = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_dir = 1'b0;
    logic [3:0] len = '0;
    logic [7:0] wdata;
    logic       wvalid = 1'b1;
    logic       wready, rvalid, done, err, busy, per_rst_n, sclk, mosi, miso, cs_n;
    logic [7:0] rdata;
    logic       rst_req = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    spi_frame_master #(.HALF_DIV(HD), .RST_CYCLES(RC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .wr_dir(wr_dir),
        .len(len), .wdata(wdata), .wvalid(wvalid), .wready(wready),
        .rdata(rdata), .rvalid(rvalid), .done(done), .err(err), .busy(busy),
        .rst_req(rst_req), .per_rst_n(per_rst_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] wpat(input int i);
        return 8'hC3 ^ 8'(i * 37);
    endfunction
    function automatic logic [7:0] rpat(input int j);
        return 8'h96 + 8'(j * 59);
    endfunction
    function automatic logic miso_bit(input int n);
        logic [7:0] b;
        if (n < 16) return 1'b0;
        b = rpat((n - 16) / 8);
        return b[7 - ((n - 16) % 8)];
    endfunction

    // Peripheral model: capture mosi on rising sclk, present next miso bit.
    int rise_cnt = 0;
    int last_rises = 0;
    logic [7:0] cap [0:16];
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            last_rises <= rise_cnt;
            rise_cnt   <= 0;
        end else begin
            if (rise_cnt < 136) cap[rise_cnt / 8] <= {cap[rise_cnt / 8][6:0], mosi};
            rise_cnt <= rise_cnt + 1;
        end
    end
    assign miso = miso_bit(rise_cnt);

    int cs_falls = 0;
    always @(negedge cs_n) cs_falls++;

    // User-side model: write data source and read data sink.
    logic cs_d = 1'b1;
    int widx = 0;
    int rd_n = 0;
    logic [7:0] rd_got [0:15];
    int err_seen = 0;
    int done_seen = 0;
    assign wdata = wpat(widx);
    always @(posedge clk) begin
        cs_d <= cs_n;
        if (err) err_seen <= err_seen + 1;
        if (done) done_seen <= done_seen + 1;
        if (cs_d && !cs_n) begin
            widx <= 0;
            rd_n <= 0;
        end else begin
            if (wvalid && wready) widx <= widx + 1;
            if (rvalid) begin
                if (rd_n < 16) rd_got[rd_n] <= rdata;
                rd_n <= rd_n + 1;
            end
        end
    end

    // Phase-width and mosi-stability monitors sampled on falling clock edges.
    int hi_run = 0, hi_min = 9999, hi_max = 0, mosi_viol = 0;
    logic sclk_p = 1'b0, mosi_p = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk) hi_run++;
            else if (hi_run > 0) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
                hi_run = 0;
            end
            if (sclk && !sclk_p && mosi != mosi_p) mosi_viol++;
            if (sclk && sclk_p && mosi != mosi_p) mosi_viol++;
        end
        sclk_p = sclk;
        mosi_p = mosi;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [7:0] a, input logic w, input logic [3:0] n);
        @(negedge clk);
        addr = a; wr_dir = w; len = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
    endtask

    task automatic t_reset_state();
        chk(cs_n == 1'b1, "R1", "cs_n idle", int'(cs_n), 1);
        chk(sclk == 1'b0, "R3", "sclk idle", int'(sclk), 0);
        chk(busy == 1'b0, "R8", "busy idle", int'(busy), 0);
        chk(per_rst_n == 1'b1, "R10", "per_rst_n idle", int'(per_rst_n), 1);
        chk(wready == 1'b0, "R5", "wready idle", int'(wready), 0);
    endtask

    task automatic t_write(input logic [7:0] a, input int n);
        bit seen;
        int f0 = cs_falls;
        pulse_start(a, 1'b1, 4'(n));
        chk(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
        chk(cs_n == 1'b0, "R1", "cs_n low in window", int'(cs_n), 0);
        wait_done(seen);
        chk(seen, "R8", "done pulse seen", int'(seen), 1);
        chk(cs_n && !busy, "R8", "cs_n high and busy low with done", int'({cs_n, busy}), 2);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done one cycle", int'(done), 0);
        chk(cs_falls - f0 == 1, "R1", "one window", cs_falls - f0, 1);
        chk(cap[0] == a, "R1", "address byte", int'(cap[0]), int'(a));
        chk(cap[1] == {1'b1, 3'b000, 4'(n)}, "R2", "write control byte", int'(cap[1]), int'({1'b1, 3'b000, 4'(n)}));
        chk(last_rises == 8 * (n + 2), "R4", "rising edges", last_rises, 8 * (n + 2));
        for (int i = 0; i < n; i++)
            chk(cap[2 + i] == wpat(i), "R5", "write data byte", int'(cap[2 + i]), int'(wpat(i)));
    endtask

    task automatic t_read(input logic [7:0] a, input int n);
        bit seen;
        pulse_start(a, 1'b0, 4'(n));
        wait_done(seen);
        chk(seen, "R8", "read done seen", int'(seen), 1);
        @(negedge clk);
        chk(cap[0] == a, "R1", "read address byte", int'(cap[0]), int'(a));
        chk(cap[1] == {4'b0000, 4'(n)}, "R2", "read control byte", int'(cap[1]), int'({4'b0000, 4'(n)}));
        chk(last_rises == 8 * (n + 2), "R4", "read rising edges", last_rises, 8 * (n + 2));
        chk(rd_n == n, "R6", "rvalid count", rd_n, n);
        for (int j = 0; j < n; j++) begin
            chk(rd_got[j] == rpat(j), "R6", "read byte", int'(rd_got[j]), int'(rpat(j)));
            chk(cap[2 + j] == 8'h00, "R6", "mosi zero in read data", int'(cap[2 + j]), 0);
        end
    endtask

    task automatic t_zero_len();
        int f0 = cs_falls;
        int e0 = err_seen;
        pulse_start(8'h44, 1'b1, 4'd0);
        chk(err == 1'b1, "R7", "err next cycle", int'(err), 1);
        chk(busy == 1'b0 && cs_n == 1'b1, "R7", "no activity", int'({busy, cs_n}), 1);
        @(negedge clk);
        chk(err == 1'b0, "R7", "err one cycle", int'(err), 0);
        repeat (20) @(negedge clk);
        chk(cs_falls == f0, "R7", "no cs fall", cs_falls - f0, 0);
        chk(err_seen - e0 == 1, "R7", "single err pulse", err_seen - e0, 1);
    endtask

    task automatic t_busy_ignore();
        bit seen;
        int f0 = cs_falls;
        int e0 = err_seen;
        int d0 = done_seen;
        pulse_start(8'h11, 1'b0, 4'd1);
        repeat (20) @(negedge clk);
        pulse_start(8'h77, 1'b1, 4'd3);
        repeat (5) @(negedge clk);
        pulse_start(8'h78, 1'b1, 4'd0);
        wait_done(seen);
        repeat (30) @(negedge clk);
        chk(cs_falls - f0 == 1, "R9", "single window", cs_falls - f0, 1);
        chk(cap[0] == 8'h11, "R9", "address unchanged", int'(cap[0]), 8'h11);
        chk(last_rises == 24, "R9", "edge count unchanged", last_rises, 24);
        chk(err_seen == e0, "R9", "no err while busy", err_seen - e0, 0);
        chk(done_seen - d0 == 1, "R9", "one done", done_seen - d0, 1);
    endtask

    task automatic t_stall();
        bit seen;
        bit got;
        wvalid = 1'b0;
        pulse_start(8'hA7, 1'b1, 4'd2);
        got = 1'b0;
        for (int i = 0; i < 2000 && !got; i++) begin
            @(negedge clk);
            if (wready) got = 1'b1;
        end
        chk(got, "R5", "wready raised", int'(got), 1);
        chk(rise_cnt == 16, "R5", "edges before stall", rise_cnt, 16);
        repeat (40) @(negedge clk);
        chk(rise_cnt == 16 && sclk == 1'b0, "R5", "clock frozen in stall", rise_cnt, 16);
        chk(wready == 1'b1, "R5", "wready held", int'(wready), 1);
        wvalid = 1'b1;
        wait_done(seen);
        @(negedge clk);
        chk(cap[2] == wpat(0) && cap[3] == wpat(1), "R5", "data after stall", int'(cap[3]), int'(wpat(1)));
    endtask

    task automatic t_per_reset();
        int lo = 0;
        int f0 = cs_falls;
        int e0 = err_seen;
        @(negedge clk);
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        chk(per_rst_n == 1'b0, "R10", "reset asserted next cycle", int'(per_rst_n), 0);
        for (int i = 0; i < 200 && !per_rst_n; i++) begin
            lo++;
            if (lo == 3) start = 1'b1;
            if (lo == 4) start = 1'b0;
            addr = 8'h5E; wr_dir = 1'b0; len = 4'd0;
            if (lo == 5) len = 4'd2;
            if (lo == 5) start = 1'b1;
            if (lo == 6) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk(lo == RC, "R10", "reset low length", lo, RC);
        chk(cs_falls == f0 && !busy, "R10", "no start in reset", cs_falls - f0, 0);
        chk(err_seen == e0, "R10", "no err in reset", err_seen - e0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_write(8'h5A, 3);
        chk(hi_min == HD && hi_max == HD, "R11", "sclk high width", hi_max, HD);
        chk(mosi_viol == 0, "R3", "mosi stable around rise", mosi_viol, 0);
        t_read(8'h3C, 2);
        t_read(8'hE1, 15);
        t_write(8'h81, 1);
        t_zero_len();
        t_busy_ignore();
        t_stall();
        t_per_reset();
        t_read(8'h5E, 2);
        chk(mosi_viol == 0, "R3", "mosi stable overall", mosi_viol, 0);
        chk(hi_min == HD && hi_max == HD, "R11", "sclk high width overall", hi_min, HD);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule